// File: doc/BRIEF.md
# Condition-Code Branch Resolution Unit

This block decides conditional branches while the branch is in the decode stage of a five-stage in-order pipeline. It keeps four scalar condition flags (zero, negative, positive, overflow), which are loaded from the result of any execute-stage instruction that asks for a flag update. When such an instruction is in execute in the same cycle as a branch in decode, its new flags go straight to the branch. The branch does not see the older stored copy.

A branch can test the scalar flags. It can also test the per-lane flags of a wide packed datapath in two forms: taken when every active lane meets the test, or taken when no active lane meets it. In the same cycle the unit works out the target address, which is either relative to the branch's own address or a base register plus an offset. It also works out the return-address write for calls. One delay slot follows every branch and the decision is purely combinational, so the pipeline never stalls for a branch.

Top module: `branch_resolve_unit`

## Requirements
- R1: The stored flags are eq (result zero), lt (result bit 31 set), gt (result non-zero with bit 31 clear) and ov (the ALU overflow input). Reset clears all four.
- R2: The stored flags load only on a clock edge where `ex_valid` and `ex_set_cc` are both high. On any other edge they keep their value.
- R3: `br_cond` selects the test: 000 always, 001 eq, 010 not eq, 011 lt, 100 lt or eq, 101 gt, 110 gt or eq, 111 ov.
- R4: When `ex_valid` and `ex_set_cc` are high in the same cycle as a scalar branch, the branch tests the flags of the current `ex_result`/`ex_ovf`. The stored flags are not used.
- R5: `target` is the base plus the sign-extended 16-bit offset shifted left by two. The base is `br_base` when `br_use_base` is 1 and `br_pc` otherwise. All of this happens in the same cycle.
- R6: `link_we` is high only when the branch is taken and `br_link` is 1. In that case `link_reg` is 31 and `link_data` is `br_pc + 8`.
- R7: `br_kind` 01 is branch-on-all. It is taken when every active lane's flags meet the condition. Lane i's flags sit at `lane_cc[4i+3:4i]` with bit 0 eq, bit 1 lt, bit 2 gt and bit 3 ov.
- R8: `br_kind` 10 is branch-on-none. It is taken when no active lane meets the condition.
- R9: `lane_width` 00 makes 32 lanes active, 01 makes 16 active, and 10 or 11 makes 8 active. The active lanes are always the lowest-numbered ones. Lanes above the active count never change the outcome.
- R10: `br_kind` 00 is a scalar branch and `br_kind` 11 is never taken. `redirect` is low whenever `br_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ex_valid | input | 1 | Execute-stage instruction valid |
| ex_set_cc | input | 1 | Execute-stage instruction updates flags |
| ex_result | input | 32 | Execute-stage ALU result |
| ex_ovf | input | 1 | Execute-stage ALU overflow |
| br_valid | input | 1 | Branch present in decode |
| br_kind | input | 2 | 00 scalar, 01 all lanes, 10 no lane, 11 never |
| br_cond | input | 3 | Condition select |
| br_link | input | 1 | Write return address on taken |
| br_use_base | input | 1 | 1: base register addressing, 0: PC-relative |
| br_offset | input | 16 | Signed word offset |
| br_pc | input | 32 | Address of the branch |
| br_base | input | 32 | Base register value |
| lane_width | input | 2 | Packed lane size: 00 8-bit, 01 16-bit, 10/11 32-bit |
| lane_cc | input | 128 | Four flags per lane, up to 32 lanes |
| redirect | output | 1 | Branch taken |
| target | output | 32 | Branch target address |
| link_we | output | 1 | Return-address write request |
| link_reg | output | 5 | Register written by the link |
| link_data | output | 32 | Return address |

## Verification
The hardest case to reach is a flag-setting instruction in execute in the same cycle as a scalar branch whose result disagrees with the stored flags. The stimulus gives each cycle a fair chance of both a flag update and a branch, and it pulls results from zero, negative and positive pools, so the two flag sets differ often. Lane tests also need near-uniform lane flags, or branch-on-all would almost never be taken. The stimulus therefore builds each lane vector from one common nibble with a few lanes changed. Directed cases then load the lanes above the active count with values that contradict the test.

// File: rtl/brres_pkg.sv
package brres_pkg;

    typedef struct packed {
        logic ov;
        logic gt;
        logic lt;
        logic eq;
    } cc_flags_t;

    typedef enum logic [2:0] {
        C_ALWAYS = 3'b000,
        C_EQ     = 3'b001,
        C_NE     = 3'b010,
        C_LT     = 3'b011,
        C_LE     = 3'b100,
        C_GT     = 3'b101,
        C_GE     = 3'b110,
        C_OV     = 3'b111
    } cond_e;

    typedef enum logic [1:0] {
        K_SCALAR = 2'b00,
        K_ALL    = 2'b01,
        K_NONE   = 2'b10,
        K_NEVER  = 2'b11
    } br_kind_e;

    function automatic logic cond_hit(cc_flags_t f, cond_e c);
        logic r;
        case (c)
            C_ALWAYS: r = 1'b1;
            C_EQ:     r = f.eq;
            C_NE:     r = !f.eq;
            C_LT:     r = f.lt;
            C_LE:     r = f.lt | f.eq;
            C_GT:     r = f.gt;
            C_GE:     r = f.gt | f.eq;
            default:  r = f.ov;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cc_store.sv
module cc_store
    import brres_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd_valid,
    input  logic              upd_set,
    input  logic [DATA_W-1:0] upd_result,
    input  logic              upd_ovf,
    output cc_flags_t         flags_eff
);

    cc_flags_t flags_q;
    cc_flags_t flags_new;
    logic      upd_en;

    always_comb begin
        flags_new.eq = (upd_result == '0);
        flags_new.lt = upd_result[DATA_W-1];
        flags_new.gt = (upd_result != '0) && !upd_result[DATA_W-1];
        flags_new.ov = upd_ovf;
    end

    assign upd_en    = upd_valid && upd_set;
    assign flags_eff = upd_en ? flags_new : flags_q;

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (upd_en)
            flags_q <= flags_new;
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !upd_en |=> $stable(flags_q));

    assert_sign_excl_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flags_q.eq, flags_q.lt, flags_q.gt}));

    assert_fwd_match_R4: assert property (@(posedge clk) disable iff (rst)
        upd_en |=> flags_q == $past(flags_eff));

endmodule

// File: rtl/lane_reduce.sv
module lane_reduce
    import brres_pkg::*;
#(
    parameter int LANES = 32
) (
    input  logic [4*LANES-1:0] lane_cc,
    input  logic [1:0]         lane_width,
    input  cond_e              cond,
    output logic               all_hit,
    output logic               none_hit
);

    localparam int CNT_W = $clog2(LANES + 1);

    logic [CNT_W-1:0] active_n;
    logic [LANES-1:0] pass;
    logic [LANES-1:0] active;

    always_comb begin
        case (lane_width)
            2'b00:   active_n = CNT_W'(LANES);
            2'b01:   active_n = CNT_W'(LANES / 2);
            default: active_n = CNT_W'(LANES / 4);
        endcase
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign pass[i]   = cond_hit(cc_flags_t'(lane_cc[4*i +: 4]), cond);
        assign active[i] = active_n > CNT_W'(i);
    end

    assign all_hit  = &(pass | ~active);
    assign none_hit = ~|(pass & active);

endmodule

// File: rtl/target_gen.sv
module target_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] base_reg,
    input  logic              use_base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] ret_addr
);

    localparam int SHIFT     = 2;
    localparam int RET_DELTA = 8;

    logic [ADDR_W-1:0] off_bytes;
    logic [ADDR_W-1:0] base_sel;

    assign off_bytes = {{(ADDR_W-OFF_W-SHIFT){offset[OFF_W-1]}}, offset, {SHIFT{1'b0}}};
    assign base_sel  = use_base ? base_reg : pc;
    assign target    = base_sel + off_bytes;
    assign ret_addr  = pc + ADDR_W'(RET_DELTA);

endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
    import brres_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int DATA_W   = 32,
    parameter int OFF_W    = 16,
    parameter int LANES    = 32,
    parameter int LINK_IDX = 31,
    localparam int CC_W    = 4 * LANES,
    localparam int REG_W   = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ex_valid,
    input  logic              ex_set_cc,
    input  logic [DATA_W-1:0] ex_result,
    input  logic              ex_ovf,
    input  logic              br_valid,
    input  logic [1:0]        br_kind,
    input  logic [2:0]        br_cond,
    input  logic              br_link,
    input  logic              br_use_base,
    input  logic [OFF_W-1:0]  br_offset,
    input  logic [ADDR_W-1:0] br_pc,
    input  logic [ADDR_W-1:0] br_base,
    input  logic [1:0]        lane_width,
    input  logic [CC_W-1:0]   lane_cc,
    output logic              redirect,
    output logic [ADDR_W-1:0] target,
    output logic              link_we,
    output logic [REG_W-1:0]  link_reg,
    output logic [ADDR_W-1:0] link_data
);

    cc_flags_t flags_eff;
    logic      all_hit;
    logic      none_hit;
    logic      taken;

    cc_store #(.DATA_W(DATA_W)) i_cc_store (
        .clk        (clk),
        .rst        (rst),
        .upd_valid  (ex_valid),
        .upd_set    (ex_set_cc),
        .upd_result (ex_result),
        .upd_ovf    (ex_ovf),
        .flags_eff  (flags_eff)
    );

    lane_reduce #(.LANES(LANES)) i_lane_reduce (
        .lane_cc    (lane_cc),
        .lane_width (lane_width),
        .cond       (cond_e'(br_cond)),
        .all_hit    (all_hit),
        .none_hit   (none_hit)
    );

    target_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) i_target_gen (
        .pc       (br_pc),
        .base_reg (br_base),
        .use_base (br_use_base),
        .offset   (br_offset),
        .target   (target),
        .ret_addr (link_data)
    );

    always_comb begin
        case (br_kind_e'(br_kind))
            K_SCALAR: taken = cond_hit(flags_eff, cond_e'(br_cond));
            K_ALL:    taken = all_hit;
            K_NONE:   taken = none_hit;
            default:  taken = 1'b0;
        endcase
    end

    assign redirect = br_valid && taken;
    assign link_we  = redirect && br_link;
    assign link_reg = REG_W'(LINK_IDX);

    assert_link_needs_taken_R6: assert property (@(posedge clk) disable iff (rst)
        link_we |-> redirect && br_link);

    assert_idle_no_redirect_R10: assert property (@(posedge clk) disable iff (rst)
        !br_valid |-> !redirect);

    assert_all_none_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(all_hit && none_hit));

endmodule

// File: tb/test_branch_resolve_unit.sv
module test_branch_resolve_unit;

    logic         clk = 0;
    logic         rst;
    logic         ex_valid, ex_set_cc, ex_ovf;
    logic [31:0]  ex_result;
    logic         br_valid, br_link, br_use_base;
    logic [1:0]   br_kind, lane_width;
    logic [2:0]   br_cond;
    logic [15:0]  br_offset;
    logic [31:0]  br_pc, br_base;
    logic [127:0] lane_cc;
    logic         redirect, link_we;
    logic [31:0]  target, link_data;
    logic [4:0]   link_reg;

    int n_tests = 0;
    int n_fail  = 0;
    logic [3:0] m_flags;  // {ov,gt,lt,eq}

    always #2.5 clk = ~clk;

    branch_resolve_unit i_branch_resolve_unit (
        .clk(clk), .rst(rst), .ex_valid(ex_valid), .ex_set_cc(ex_set_cc),
        .ex_result(ex_result), .ex_ovf(ex_ovf), .br_valid(br_valid),
        .br_kind(br_kind), .br_cond(br_cond), .br_link(br_link),
        .br_use_base(br_use_base), .br_offset(br_offset), .br_pc(br_pc),
        .br_base(br_base), .lane_width(lane_width), .lane_cc(lane_cc),
        .redirect(redirect), .target(target), .link_we(link_we),
        .link_reg(link_reg), .link_data(link_data)
    );

    function automatic logic [3:0] flags_of(logic [31:0] r, logic o);
        return {o, (r != 0) && !r[31], r[31], r == 0};
    endfunction

    function automatic logic test_of(logic [3:0] f, logic [2:0] c);
        case (c)
            3'd0: return 1'b1;
            3'd1: return f[0];
            3'd2: return !f[0];
            3'd3: return f[1];
            3'd4: return f[1] | f[0];
            3'd5: return f[2];
            3'd6: return f[2] | f[0];
            default: return f[3];
        endcase
    endfunction

    function automatic logic exp_taken();
        logic [3:0] f;
        int   n;
        logic all_ok, any_ok;
        f = (ex_valid && ex_set_cc) ? flags_of(ex_result, ex_ovf) : m_flags;
        n = (lane_width == 2'b00) ? 32 : (lane_width == 2'b01) ? 16 : 8;
        all_ok = 1'b1;
        any_ok = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (test_of(lane_cc[4*i +: 4], br_cond)) any_ok = 1'b1;
            else all_ok = 1'b0;
        end
        if (!br_valid) return 1'b0;
        case (br_kind)
            2'b00: return test_of(f, br_cond);
            2'b01: return all_ok;
            2'b10: return !any_ok;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at negedge, check 1ns later, then let the edge update the flag model.
    task automatic check_step(string req);
        logic t;
        logic [31:0] sx;
        #1;
        t  = exp_taken();
        sx = {{16{br_offset[15]}}, br_offset};
        chk(req, {31'b0, redirect}, {31'b0, t});
        chk("R5", target, (br_use_base ? br_base : br_pc) + (sx << 2));
        chk("R6", {31'b0, link_we}, {31'b0, t && br_link});
        if (t && br_link) begin
            chk("R6", {27'b0, link_reg}, 32'd31);
            chk("R6", link_data, br_pc + 32'd8);
        end
        @(posedge clk);
        if (ex_valid && ex_set_cc) m_flags = flags_of(ex_result, ex_ovf);
        @(negedge clk);
    endtask

    task automatic idle();
        ex_valid = 0; ex_set_cc = 0; ex_result = 0; ex_ovf = 0;
        br_valid = 0; br_kind = 0; br_cond = 0; br_link = 0; br_use_base = 0;
        br_offset = 0; br_pc = 32'h1000; br_base = 0; lane_width = 0; lane_cc = 0;
    endtask

    task automatic scalar_br(logic [2:0] c);
        br_valid = 1; br_kind = 2'b00; br_cond = c;
    endtask

    function automatic logic [31:0] pick_result();
        case ($urandom % 4)
            0: return 32'h0;
            1: return 32'h8000_0000 | $urandom;
            2: return {1'b0, 31'($urandom)} | 32'h1;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle();
        m_flags = 4'b0;
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: reset state clears all flags
        scalar_br(3'd1); check_step("R1");
        scalar_br(3'd2); check_step("R1");
        scalar_br(3'd6); check_step("R1");
        scalar_br(3'd7); check_step("R1");

        // R2: update without C bit is ignored, visible on the next branch
        ex_valid = 1; ex_set_cc = 0; ex_result = 0; br_valid = 0;
        check_step("R2");
        idle(); scalar_br(3'd1); check_step("R2");
        // and with C bit but invalid
        ex_valid = 0; ex_set_cc = 1; ex_result = 0; check_step("R2");
        idle(); scalar_br(3'd1); check_step("R2");

        // R4: forward zero result to same-cycle branch eq
        ex_valid = 1; ex_set_cc = 1; ex_result = 0; scalar_br(3'd1); check_step("R4");
        idle(); scalar_br(3'd1); check_step("R1");
        // negative and overflow forwarded
        ex_valid = 1; ex_set_cc = 1; ex_result = 32'hFFFF_FFF0; ex_ovf = 1;
        scalar_br(3'd4); check_step("R4");
        idle(); scalar_br(3'd7); check_step("R3");
        scalar_br(3'd5); check_step("R3");

        // R5/R6: base mode, negative offset, linking call
        idle(); br_valid = 1; br_kind = 2'b00; br_cond = 3'd0; br_link = 1;
        br_use_base = 1; br_base = 32'h0002_0000; br_offset = 16'hFFFF; check_step("R6");
        br_use_base = 0; br_offset = 16'h7FFF; br_pc = 32'hFFFF_FFFC; check_step("R5");

        // R10: kind 11 never taken, invalid never redirects
        idle(); br_valid = 1; br_kind = 2'b11; br_cond = 3'd0; check_step("R10");
        br_valid = 0; br_kind = 2'b00; check_step("R10");

        // R7/R9: upper lanes fail but width makes them inactive
        idle(); br_valid = 1; br_kind = 2'b01; br_cond = 3'd1;
        lane_cc = {96'h0, {8{4'b0001}}}; lane_width = 2'b10; check_step("R9");
        lane_width = 2'b01; check_step("R9");
        lane_cc = {64'h0, {16{4'b0001}}}; check_step("R7");
        lane_cc = {32{4'b0001}}; lane_width = 2'b00; check_step("R7");
        lane_cc[127:124] = 4'b0010; check_step("R7");
        // R8/R9: upper lanes pass but are inactive
        br_kind = 2'b10; lane_cc = {{24{4'b0001}}, {8{4'b0100}}}; lane_width = 2'b11;
        check_step("R9");
        lane_width = 2'b01; check_step("R8");
        br_cond = 3'd0; check_step("R8");
        br_kind = 2'b01; check_step("R7");

        // Random mix
        for (int k = 0; k < 3000; k++) begin
            logic [3:0] bn;
            ex_valid = ($urandom % 3) != 0; ex_set_cc = ($urandom % 2) != 0;
            ex_result = pick_result(); ex_ovf = ($urandom % 4) == 0;
            br_valid = ($urandom % 5) != 0; br_kind = 2'($urandom);
            br_cond = 3'($urandom); br_link = 1'($urandom);
            br_use_base = 1'($urandom); br_offset = 16'($urandom);
            br_pc = $urandom & 32'hFFFF_FFFC; br_base = $urandom;
            lane_width = 2'($urandom);
            bn = 4'($urandom);
            for (int i = 0; i < 32; i++)
                lane_cc[4*i +: 4] = (($urandom % 8) == 0) ? 4'($urandom) : bn;
            case (br_kind)
                2'b00: check_step("R3");
                2'b01: check_step("R7");
                2'b10: check_step("R8");
                default: check_step("R10");
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule